// File: doc/BRIEF.md
# Byte Serializer-Deserializer with Loopback and Loop-Timing Paths

This block sits between an 8-bit parallel datapath and a one-bit line stream. The transmit half takes a byte from a parallel bus and sends it out one bit at a time, most significant bit first. The receive half gathers incoming bits into bytes, with the first bit landing in the most significant position. It raises a one-cycle valid strobe for each finished byte. Each half also produces a byte-rate clock that runs at one eighth of its bit rate.

Everything runs on one fast clock `clk`. Bit timing comes from two strobes that act as clock enables. `ref_tick` stands for the internally multiplied bit clock. `rx_tick` stands for the clock recovered from the line. Three mode selects rearrange the datapath:
- **Equipment loopback** feeds the transmit bit stream into the deserializer. The deserializer is then clocked by the transmit bit strobe.
- **Facility loopback** sends the received line bit straight to the serial output.
- **Split loopback** is both loopbacks at once. The two normal paths are then cut.
- **Loop timing** moves the transmit side onto the recovered strobe, so the whole block runs from one timing source.

An alignment pulse restarts byte assembly on the receive side.

Top module: `byte_serdes_lb`

## Requirements
- R1: While `rst` is high, and in the first output sample after it, `tx_sdo`, `tx_byte_clk`, `rx_byte`, `rx_byte_valid` and `rx_byte_clk` are all 0. Both bit phases restart at 0.
- R2: Each transmit step shifts one bit out. A step taken at transmit phase 0 samples `tx_byte` and presents its bit 7 at once. The next seven steps present bits 6 down to 0. Without facility loopback, `tx_sdo` carries the presented bit from the clock edge of the step onward.
- R3: `tx_byte_clk` is registered. It is 1 while the transmit phase after the latest step is 4 to 7, and 0 while it is 0 to 3. It therefore runs at the bit rate divided by 8.
- R4: Each receive step shifts one bit in. On the eighth step since the last byte or alignment, `rx_byte` takes the eight bits with the first one in bit 7. `rx_byte_valid` is 1 for exactly one `clk` cycle, right after that edge.
- R5: `rx_byte_clk` is 1 while the receive phase after the latest step or alignment is 4 to 7, and 0 otherwise.
- R6: A cycle with `rx_align` high clears the receive phase and any partly gathered bits, and it ignores a receive step in the same cycle. The next receive step after that becomes bit 7 of a new byte.
- R7: With `eq_loop` high, the deserializer takes the transmit presented bit as it stood before each step, in place of `rx_sdi`. Its steps then follow the transmit step.
- R8: With `fac_loop` high, each `rx_tick` cycle loads `tx_sdo` with `rx_sdi`, and `tx_sdo` holds between ticks. The serializer keeps running, but its bits do not reach `tx_sdo`.
- R9: With both loopbacks high, `rx_sdi` has no effect on `rx_byte`, and `tx_byte` has no effect on `tx_sdo`.
- R10: With `loop_timing` high, the transmit step is `rx_tick`, and `ref_tick` has no effect on any output. With it low, the transmit step is `ref_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock, all logic on its rising edge |
| rst | input | 1 | synchronous active-high reset |
| ref_tick | input | 1 | bit strobe of the internal multiplied clock |
| rx_tick | input | 1 | bit strobe of the recovered receive clock |
| loop_timing | input | 1 | transmit side timed from `rx_tick` |
| eq_loop | input | 1 | equipment loopback select |
| fac_loop | input | 1 | facility loopback select |
| tx_byte | input | 8 | parallel transmit byte |
| rx_sdi | input | 1 | received serial bit |
| rx_align | input | 1 | restart receive byte assembly |
| tx_sdo | output | 1 | transmitted serial bit |
| tx_byte_clk | output | 1 | transmit byte-rate clock |
| rx_byte | output | 8 | last assembled receive byte |
| rx_byte_valid | output | 1 | one-cycle strobe per assembled byte |
| rx_byte_clk | output | 1 | receive byte-rate clock |

## Verification
Each of the six mode combinations runs with independent, irregular `ref_tick` and `rx_tick` patterns, random serial data and random parallel bytes. The irregular strobes make any mix-up of the two timing sources visible. Random bytes show up a bit-order or load-phase error. Equipment loopback with a sparse receive strobe shows whether the deserializer really follows the transmit step. Split mode and the loop-timing phases toggle the input that should be cut off. Occasional alignment pulses, some landing on a receive step, separate the align priority from plain assembly.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef struct packed {
    logic lt;
    logic eq;
    logic fac;
  } lb_mode_t;

  function automatic logic half_high(input int unsigned phase, input int unsigned width);
    return (phase >= (width / 2));
  endfunction
endpackage

// File: rtl/lb_path_sel.sv
module lb_path_sel
  import lb_pkg::*;
(
  input  lb_mode_t mode,
  input  logic     ref_tick,
  input  logic     rx_tick,
  input  logic     rx_sdi,
  input  logic     tx_bit,
  output logic     tx_step,
  output logic     rx_step,
  output logic     rx_din
);
  // Loop timing puts the transmit side onto recovered timing (R10).
  always_comb tx_step = mode.lt ? rx_tick : ref_tick;
  // Equipment loopback makes the deserializer follow the transmit stream (R7).
  always_comb rx_step = mode.eq ? tx_step : rx_tick;
  always_comb rx_din  = mode.eq ? tx_bit  : rx_sdi;
endmodule

// File: rtl/lb_tx_ser.sv
module lb_tx_ser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] par_in,
  input  logic         fac,
  input  logic         fac_step,
  input  logic         fac_bit,
  output logic         bit_cur,
  output logic         sdo,
  output logic         byte_clk
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic [W-1:0]  sh;
  logic          nbit;

  always_comb begin
    nbit    = (cnt == '0) ? par_in[W-1] : sh[W-1];
    cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sh       <= '0;
      bit_cur  <= 1'b0;
      sdo      <= 1'b0;
      byte_clk <= 1'b0;
    end else begin
      if (step) begin
        bit_cur  <= nbit;
        sh       <= ((cnt == '0) ? par_in : sh) << 1;
        cnt      <= cnt_nxt;
        byte_clk <= lb_pkg::half_high(int'(cnt_nxt), W);
      end
      if (fac) begin
        if (fac_step) sdo <= fac_bit;
      end else if (step) begin
        sdo <= nbit;
      end
    end
  end

  assert_load_msb_R2: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == '0) |=> (bit_cur == $past(par_in[W-1])));
  assert_fac_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (fac && fac_step) |=> (sdo == $past(fac_bit)));
  assert_bclk_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!step) |=> $stable(byte_clk));
endmodule

// File: rtl/lb_rx_deser.sv
module lb_rx_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         din,
  input  logic         align,
  output logic [W-1:0] byte_out,
  output logic         valid,
  output logic         byte_clk
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic [W-1:0]  sh, sh_nxt;

  always_comb begin
    sh_nxt  = {sh[W-2:0], din};
    cnt_nxt = (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sh       <= '0;
      byte_out <= '0;
      valid    <= 1'b0;
      byte_clk <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (align) begin
        cnt      <= '0;
        sh       <= '0;
        byte_clk <= 1'b0;
      end else if (step) begin
        sh       <= sh_nxt;
        cnt      <= cnt_nxt;
        byte_clk <= lb_pkg::half_high(int'(cnt_nxt), W);
        if (cnt == LAST) begin
          byte_out <= sh_nxt;
          valid    <= 1'b1;
        end
      end
    end
  end

  assert_align_clear_R6: assert property (@(posedge clk) disable iff (rst)
    align |=> (cnt == '0 && !valid && !byte_clk));
  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  assert_valid_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    valid |-> (cnt == '0 && !byte_clk));
endmodule

// File: rtl/byte_serdes_lb.sv
module byte_serdes_lb
  import lb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ref_tick,
  input  logic         rx_tick,
  input  logic         loop_timing,
  input  logic         eq_loop,
  input  logic         fac_loop,
  input  logic [W-1:0] tx_byte,
  input  logic         rx_sdi,
  input  logic         rx_align,
  output logic         tx_sdo,
  output logic         tx_byte_clk,
  output logic [W-1:0] rx_byte,
  output logic         rx_byte_valid,
  output logic         rx_byte_clk
);
  lb_mode_t mode;
  logic tx_step, rx_step, rx_din, tx_bit;

  always_comb begin
    mode.lt  = loop_timing;
    mode.eq  = eq_loop;
    mode.fac = fac_loop;
  end

  lb_path_sel u_sel (
    .mode(mode), .ref_tick(ref_tick), .rx_tick(rx_tick), .rx_sdi(rx_sdi),
    .tx_bit(tx_bit), .tx_step(tx_step), .rx_step(rx_step), .rx_din(rx_din)
  );

  lb_tx_ser #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .step(tx_step), .par_in(tx_byte),
    .fac(fac_loop), .fac_step(rx_tick), .fac_bit(rx_sdi),
    .bit_cur(tx_bit), .sdo(tx_sdo), .byte_clk(tx_byte_clk)
  );

  lb_rx_deser #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .step(rx_step), .din(rx_din), .align(rx_align),
    .byte_out(rx_byte), .valid(rx_byte_valid), .byte_clk(rx_byte_clk)
  );

  // R9: in split mode the line output follows the line input only.
  assert_split_cut_R9: assert property (@(posedge clk) disable iff (rst)
    (eq_loop && fac_loop && !rx_tick) |=> $stable(tx_sdo));
  // R10: under loop timing nothing moves on the transmit side without rx_tick.
  assert_loop_time_R10: assert property (@(posedge clk) disable iff (rst)
    (loop_timing && !rx_tick) |=> $stable(tx_byte_clk));
endmodule

// File: tb/tb_byte_serdes_lb.sv
`timescale 1ns/1ps
module tb_byte_serdes_lb;
  logic clk = 0, rst = 1;
  logic ref_tick = 0, rx_tick = 0, loop_timing = 0, eq_loop = 0, fac_loop = 0;
  logic [7:0] tx_byte = 0;
  logic rx_sdi = 0, rx_align = 0;
  logic tx_sdo, tx_byte_clk, rx_byte_valid, rx_byte_clk;
  logic [7:0] rx_byte;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1 reset";

  always #2.5 clk = ~clk;

  byte_serdes_lb dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .rx_tick(rx_tick),
    .loop_timing(loop_timing), .eq_loop(eq_loop), .fac_loop(fac_loop),
    .tx_byte(tx_byte), .rx_sdi(rx_sdi), .rx_align(rx_align),
    .tx_sdo(tx_sdo), .tx_byte_clk(tx_byte_clk), .rx_byte(rx_byte),
    .rx_byte_valid(rx_byte_valid), .rx_byte_clk(rx_byte_clk)
  );

  // Behavioural reference: bit queues and phase integers.
  bit tq[$];
  bit rq[$];
  int tphase = 0, rphase = 0;
  bit m_tbit = 0, m_sdo = 0, m_rval = 0;
  int m_rbyte = 0;

  always @(posedge clk) begin
    if (rst) begin
      tq.delete(); rq.delete();
      tphase = 0; rphase = 0; m_tbit = 0; m_sdo = 0; m_rval = 0; m_rbyte = 0;
    end else begin
      bit ts, rs, rin;
      ts  = loop_timing ? rx_tick : ref_tick;
      rs  = eq_loop ? ts : rx_tick;
      rin = eq_loop ? m_tbit : rx_sdi;
      if (ts) begin
        if (tq.size() == 0)
          for (int i = 7; i >= 0; i--) tq.push_back(tx_byte[i]);
        m_tbit = tq.pop_front();
        tphase = (tphase + 1) % 8;
      end
      if (fac_loop) begin
        if (rx_tick) m_sdo = rx_sdi;
      end else if (ts) m_sdo = m_tbit;
      m_rval = 0;
      if (rx_align) begin
        rq.delete(); rphase = 0;
      end else if (rs) begin
        rq.push_back(rin);
        rphase = (rphase + 1) % 8;
        if (rq.size() == 8) begin
          m_rbyte = 0;
          foreach (rq[i]) m_rbyte = (m_rbyte << 1) | int'(rq[i]);
          m_rval = 1;
          rq.delete();
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("tx_sdo", int'(tx_sdo), int'(m_sdo));
    chk("tx_byte_clk", int'(tx_byte_clk), (tphase >= 4) ? 1 : 0);
    chk("rx_byte", int'(rx_byte), m_rbyte);
    chk("rx_byte_valid", int'(rx_byte_valid), int'(m_rval));
    chk("rx_byte_clk", int'(rx_byte_clk), (rphase >= 4) ? 1 : 0);
  endtask

  // One phase: sample at negedge, then drive new inputs.
  task automatic run(string t, bit lt, bit eq, bit fac, int n, int ref_den, int rx_den);
    tag = t;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare_all();
      loop_timing = lt; eq_loop = eq; fac_loop = fac;
      ref_tick = ($urandom % ref_den) == 0;
      rx_tick  = ($urandom % rx_den) == 0;
      rx_sdi   = $urandom % 2;
      tx_byte  = 8'($urandom);
      rx_align = ($urandom % 97) == 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    tag = "R1 reset";
    chk("tx_sdo", int'(tx_sdo), 0);
    chk("rx_byte", int'(rx_byte), 0);
    chk("rx_byte_valid", int'(rx_byte_valid), 0);
    chk("tx_byte_clk", int'(tx_byte_clk), 0);
    chk("rx_byte_clk", int'(rx_byte_clk), 0);
    rst = 0;
    run("R1/R2/R3/R4/R5/R6 normal", 0, 0, 0, 1500, 2, 3);
    run("R2/R4 dense ticks", 0, 0, 0, 600, 1, 1);
    run("R7 equipment loop", 0, 1, 0, 1500, 2, 5);
    run("R8 facility loop", 0, 0, 1, 1500, 3, 2);
    run("R9 split loop", 0, 1, 1, 1500, 2, 3);
    run("R10 loop timing", 1, 0, 0, 1500, 2, 3);
    run("R10/R7 loop timing with equipment loop", 1, 1, 0, 1000, 1, 2);
    run("R6/R2 back to normal", 0, 0, 0, 800, 1, 2);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule